// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block turns four external interrupt pins into pending-interrupt flags, one per channel, each flag driving its own interrupt request line. Each pin passes through a two-stage synchronizer and can then, per channel, go through a glitch filter. The filter only passes a new level once that level has been sampled for a fixed number of consecutive clocks. The resulting channel level feeds an edge/level trigger stage. That stage sets the flag according to a 3-bit mode.

The pin value comes from the ordinary digital input path. An interrupt therefore keeps working while the same pin serves a peripheral or is driven as an output. A pin whose digital input is held constant, as in analog use, can never produce an edge and cannot act as a source.

Software clears flags through a one-cycle write strobe with a data mask. A level-triggered channel whose input is still active sets its flag again on the next clock.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is asserted and on the first clock after its release, every `irq` bit is 0.
- R2: Channel c takes its mode from `trig_mode[3c+2:3c]`. Values 0, 6 and 7 disable it, and a disabled channel never sets its flag whatever its pin does.
- R3: Mode 1 (rising edge), with the filter off: a 0-to-1 pin change sampled at clock edge k makes `irq[c]` high after edge k+2, and it stays high until cleared.
- R4: Mode 2 (falling edge) sets the flag with the same latency on a 1-to-0 pin change.
- R5: Mode 3 (both edges) sets the flag on either change.
- R6: Mode 4 sets the flag on every clock while the channel level is 1, and mode 5 does so while it is 0. A flag cleared while its level is still active is high again on the next clock.
- R7: A cycle with `clr_we` = 1 clears flag c when `clr_data[c]` = 1. A 0 in `clr_data[c]` leaves flag c unchanged, and so does `clr_we` = 0.
- R8: If a set condition and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: With `filt_en[c]` = 1, a pin level that lasts fewer than FILT_CYCLES (default 4) clocks is ignored. A level that lasts FILT_CYCLES clocks or more is accepted, FILT_CYCLES clocks later than it would be unfiltered.
- R10: Channels are independent. The pin, mode, filter and clear bit of one channel never change another channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_CH | Pin levels from the digital input path |
| trig_mode | input | 3*NUM_CH | Trigger mode per channel, channel c in bits 3c+2:3c |
| filt_en | input | NUM_CH | Glitch filter enable per channel |
| clr_we | input | 1 | Flag clear write strobe |
| clr_data | input | NUM_CH | Write-1-to-clear mask |
| irq | output | NUM_CH | Pending flags / interrupt requests |

## Verification
The bench aims at a clear that lands while a level-mode input is still active. A design that failed to re-arm would leave the flag low for good. It also places a clear in the same cycle as a new edge. If the clear won that race, the design would lose the event.

Filtered pulses one clock shorter than the threshold, and exactly as long as it, are driven on purpose. An off-by-one counter would accept the first or reject the second. Mode values 6 and 7 are applied with a toggling pin, so a design that decodes only the low bits would fire on them. A long mixed phase with per-channel random stimulus exposes any coupling between channels.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Trigger mode encoding; 6 and 7 are left unnamed and act as off
    typedef enum logic [2:0] {
        TRIG_OFF  = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_BOTH = 3'd3,
        TRIG_HIGH = 3'd4,
        TRIG_LOW  = 3'd5
    } trig_mode_e;

    // Glitch filter states
    typedef enum logic {
        FILT_HOLD  = 1'b0,   // output settled, input agrees
        FILT_TRACK = 1'b1    // input differs, counting stable samples
    } filt_state_e;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic synced
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin};
    end

    assign synced = chain_q[STAGES-1];
endmodule

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter
    import ext_irq_pkg::*;
#(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_CYCLES > 2) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    filt_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          out_q, out_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILT_HOLD;
            cnt_q   <= '0;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            out_q   <= out_d;
        end
    end

    // transitions and output update
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        unique case (state_q)
            FILT_HOLD: begin
                if (din != out_q) begin          // HOLD -> TRACK: first differing sample
                    state_d = FILT_TRACK;
                    cnt_d   = CW'(1);
                end
            end
            FILT_TRACK: begin
                if (din == out_q) begin          // TRACK -> HOLD: glitch rejected
                    state_d = FILT_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin // TRACK -> HOLD: level accepted
                    state_d = FILT_HOLD;
                    cnt_d   = '0;
                    out_d   = din;
                end else begin
                    cnt_d   = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = FILT_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    assign dout = out_q;
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic [2:0] mode,
    input  logic       clr,
    output logic       flag
);
    logic prev_q;
    logic flag_q;
    logic set_hit;

    // set condition from mode
    always_comb begin
        unique case (mode)
            TRIG_RISE: set_hit = level & ~prev_q;
            TRIG_FALL: set_hit = ~level & prev_q;
            TRIG_BOTH: set_hit = level ^ prev_q;
            TRIG_HIGH: set_hit = level;
            TRIG_LOW:  set_hit = ~level;
            default:   set_hit = 1'b0;
        endcase
    end

    // registers: previous level and pending flag (set beats clear)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= level;
            if (set_hit)  flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     pin_in,
    input  logic [3*NUM_CH-1:0]   trig_mode,
    input  logic [NUM_CH-1:0]     filt_en,
    input  logic                  clr_we,
    input  logic [NUM_CH-1:0]     clr_data,
    output logic [NUM_CH-1:0]     irq
);
    localparam int MW = 3;

    logic [NUM_CH-1:0] synced;
    logic [NUM_CH-1:0] filtered;
    logic [NUM_CH-1:0] chan_lvl;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pin_in[g]),
            .synced (synced[g])
        );

        irq_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (synced[g]),
            .dout  (filtered[g])
        );

        assign chan_lvl[g] = filt_en[g] ? filtered[g] : synced[g];

        irq_trigger u_trig (
            .clk   (clk),
            .rst_n (rst_n),
            .level (chan_lvl[g]),
            .mode  (trig_mode[g*MW +: MW]),
            .clr   (clr_we & clr_data[g]),
            .flag  (irq[g])
        );
    end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
    parameter int NUM_CH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3*NUM_CH-1:0] trig_mode,
    input logic                clr_we,
    input logic [NUM_CH-1:0]   clr_data,
    input logic [NUM_CH-1:0]   chan_lvl,
    input logic [NUM_CH-1:0]   irq
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic [2:0] m;
        logic       off;
        assign m   = trig_mode[i*3 +: 3];
        assign off = (m == 3'd0) || (m > 3'd5);

        a_r2_off_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (off && !irq[i]) |=> !irq[i]);

        a_r7_write1_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (off && clr_we && clr_data[i]) |=> !irq[i]);

        a_r7_write0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && !(clr_we && clr_data[i])) |=> irq[i]);

        a_r6_level_high_rearms: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 3'd4 && chan_lvl[i]) |=> irq[i]);

        a_r6_level_low_rearms: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 3'd5 && !chan_lvl[i]) |=> irq[i]);

        a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            ((m == 3'd4 || m == 3'd3) && clr_we && clr_data[i] &&
             (m == 3'd4 ? chan_lvl[i] : 1'b0)) |=> irq[i]);
    end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_mode (trig_mode),
    .clr_we    (clr_we),
    .clr_data  (clr_data),
    .chan_lvl  (chan_lvl),
    .irq       (irq)
);

// File: tb/tb_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_ctrl;
    localparam int NCH  = 4;
    localparam int FILT = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  pin_in = '0;
    logic [3*NCH-1:0] trig_mode = '0;
    logic [NCH-1:0]  filt_en = '0;
    logic            clr_we = 1'b0;
    logic [NCH-1:0]  clr_data = '0;
    logic [NCH-1:0]  irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string phase = "R1 reset";

    // behavioural reference state
    int s0[NCH], s1[NCH], fo[NCH], run[NCH], prv[NCH], flg[NCH];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;   // 50 MHz

    ext_irq_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(2), .FILT_CYCLES(FILT)) dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .trig_mode(trig_mode),
        .filt_en(filt_en), .clr_we(clr_we), .clr_data(clr_data), .irq(irq)
    );

    task automatic step();
        logic [NCH-1:0] exp_v;
        @(posedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                s0[c] = 0; s1[c] = 0; fo[c] = 0; run[c] = 0; prv[c] = 0; flg[c] = 0;
            end else begin
                int v, m;
                bit hit;
                v = filt_en[c] ? fo[c] : s1[c];
                m = int'(trig_mode[c*3 +: 3]);
                hit = (m == 1 && v == 1 && prv[c] == 0) || (m == 2 && v == 0 && prv[c] == 1) ||
                      (m == 3 && v != prv[c]) || (m == 4 && v == 1) || (m == 5 && v == 0);
                if (hit) flg[c] = 1;
                else if (clr_we && clr_data[c]) flg[c] = 0;
                prv[c] = v;
                if (s1[c] != fo[c]) begin
                    run[c]++;
                    if (run[c] == FILT) begin fo[c] = s1[c]; run[c] = 0; end
                end else run[c] = 0;
                s1[c] = s0[c];
                s0[c] = int'(pin_in[c]);
            end
        end
        @(negedge clk);
        for (int c = 0; c < NCH; c++) exp_v[c] = flg[c][0];
        compared++;
        if (irq !== exp_v) begin
            mismatched++;
            $display("FAIL %s: irq actual %b expected %b at %0t", phase, irq, exp_v, $time);
        end
    endtask

    task automatic run_n(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr_clr(logic [NCH-1:0] mask);
        clr_we = 1'b1; clr_data = mask;
        step();
        clr_we = 1'b0; clr_data = '0;
    endtask

    task automatic all_modes(logic [2:0] m);
        for (int c = 0; c < NCH; c++) trig_mode[c*3 +: 3] = m;
    endtask

    initial begin
        // R1: reset and first cycles after release
        run_n(3);
        rst_n = 1'b1;
        run_n(2);

        // R2: disabled encodings 0, 6, 7 with a toggling pin
        phase = "R2 disabled modes";
        trig_mode = {3'd0, 3'd7, 3'd6, 3'd0};
        for (int k = 0; k < 12; k++) begin
            pin_in = k[0] ? 4'hF : 4'h0;
            run_n(2);
        end
        pin_in = '0; run_n(6);

        // R3: rising edge, unfiltered, per-channel pulses (R10)
        phase = "R3 rising";
        all_modes(3'd1);
        pin_in = 4'b0101; run_n(3);
        pin_in = 4'b0000; run_n(6);
        pin_in = 4'b1010; run_n(5);
        pin_in = 4'b0000; run_n(4);
        wr_clr(4'hF); run_n(3);

        // R7: write-1 clears, write-0 and idle strobe keep
        phase = "R7 clear mask";
        pin_in = 4'hF; run_n(6);
        wr_clr(4'h0); run_n(2);
        clr_data = 4'hF; step(); clr_data = '0;
        wr_clr(4'b0011); run_n(2);
        wr_clr(4'b1100); run_n(2);

        // R4: falling edge
        phase = "R4 falling";
        all_modes(3'd2);
        pin_in = 4'b0110; run_n(5);
        pin_in = 4'b0000; run_n(5);
        wr_clr(4'hF); run_n(2);
        pin_in = 4'hF; run_n(4);
        wr_clr(4'hF);
        pin_in = 4'h0; run_n(5);
        wr_clr(4'hF); run_n(2);

        // R5: both edges
        phase = "R5 both edges";
        all_modes(3'd3);
        for (int k = 0; k < 6; k++) begin
            pin_in = pin_in ^ (4'b0001 << (k % 4));
            run_n(4);
            wr_clr(4'hF);
        end
        run_n(4);

        // R6: level modes re-arm after clear while active
        phase = "R6 level";
        trig_mode = {3'd5, 3'd4, 3'd5, 3'd4};
        pin_in = 4'b0101; run_n(5);
        for (int k = 0; k < 4; k++) begin wr_clr(4'hF); run_n(1); end
        pin_in = 4'b1010; run_n(5);
        wr_clr(4'hF); run_n(4);

        // R8: clear every cycle while edges arrive
        phase = "R8 set beats clear";
        all_modes(3'd3);
        clr_we = 1'b1; clr_data = 4'hF;
        for (int k = 0; k < 30; k++) begin
            if (k % 3 == 0) pin_in = ~pin_in;
            step();
        end
        clr_we = 1'b0; clr_data = '0;
        run_n(4);
        wr_clr(4'hF);

        // R9: filtered pulses around the threshold
        phase = "R9 filter";
        filt_en = 4'hF;
        all_modes(3'd3);
        run_n(10);
        wr_clr(4'hF);
        for (int w = 1; w <= 6; w++) begin
            pin_in = ~pin_in; run_n(w);
            pin_in = ~pin_in; run_n(12);
            wr_clr(4'hF); run_n(2);
        end

        // R10: independent channels under mixed stimulus
        phase = "R10 mixed";
        for (int k = 0; k < 1500; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (k % 64 == 0) begin
                trig_mode = {lfsr[2:0], lfsr[5:3], lfsr[8:6], lfsr[11:9]};
                filt_en   = lfsr[15:12];
            end
            if (lfsr[0]) pin_in = pin_in ^ lfsr[7:4];
            clr_we   = lfsr[9] & lfsr[3];
            clr_data = lfsr[13:10];
            step();
        end
        clr_we = 1'b0; clr_data = '0;
        run_n(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule